// File: doc/BRIEF.md
# Two-Tone FSK Sample Generator

This block turns a serial bit into one of two audio-band carrier tones for a 1200 bit/s forward channel. It runs from a 3.579545 MHz system clock. Each clock, a phase accumulator adds a fixed increment chosen by the current data bit. The top bits of the accumulator index a signed sine table. The block produces two outputs on every enabled clock: a signed sample word and a square-wave carrier bit.

The data bit drives the tone choice directly, with no buffering. Aligning bits to the baud rate is the job of a block upstream. Changing tones replaces only the increment, so the waveform continues from its current phase and never jumps. Deasserting the enable parks the accumulator at zero and silences both outputs. The next burst therefore always starts at phase zero.

Both outputs form a free-running stream with one new value on every clock. The block has no valid/ready pair because it never stalls. A consumer must take a sample on every cycle, or decimate the samples itself.

Top module: `fsk_tone_mod`

## Requirements
- R1: After reset, and until enable rises, `sample_o` is 0 and `square_o` is 0.
- R2: With `tx_bit` = 1 (mark), the carrier frequency is 1300 Hz within ±0.1% of the 3.579545 MHz clock, measured as clock cycles per square-wave period.
- R3: With `tx_bit` = 0 (space), the carrier frequency is 2100 Hz within ±0.1%.
- R4: While `tx_en` is high, each clock adds round(f × 2^24 / 3579545) to the 24-bit phase, using the bit present at that edge. The mark increment is 6093 and the space increment is 9843. The 20-period length therefore sits within 2 cycles of 20 × 2^24 / increment.
- R5: A tone change never resets the phase. While enabled, two consecutive samples differ by at most 4 counts, including across changes of `tx_bit`.
- R6: On the clock edge that samples `tx_en` low, the phase returns to 0. From the second such edge onward, `sample_o` and `square_o` are 0, whatever `tx_bit` does.
- R7: After `tx_en` rises, the waveform starts at phase zero. For the first 1300 cycles of a mark burst, `sample_o` is ≥ 0 and `square_o` is 0.
- R8: `square_o` equals the phase MSB. While enabled, `square_o` = 1 implies `sample_o` ≤ 0, and `square_o` = 0 implies `sample_o` ≥ 0.
- R9: The sine table is 256 entries of signed 8-bit values, addressed by phase bits [23:16]. Every full carrier cycle reaches +127 and −127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low parks the phase at zero |
| tx_bit | input | 1 | Data bit; 1 selects mark (1300 Hz), 0 selects space (2100 Hz) |
| sample_o | output | 8 | Signed sine sample, two's complement |
| square_o | output | 1 | Square-wave carrier (phase MSB) |

## Verification
The bench builds the block with its default parameters: 3579545 Hz clock, 24-bit phase, 8-bit table address and 8-bit samples. These values give a real period of about 2754 cycles for mark and 1705 cycles for space. A window of 20 periods therefore resolves one cycle in tens of thousands. That resolution is enough to test the 0.1% frequency budget, and also to pin the exact increment value in use. The same settings make every table index visible within one carrier cycle. This lets the bench observe the peak amplitude, the sign relationship and the per-sample slope at the outputs.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  // Rounded phase increment for a tone: round(f * 2^acc_w / clk)
  function automatic longint tone_step(input longint f_hz, input longint clk_hz,
                                       input int acc_w);
    return ((f_hz << acc_w) + clk_hz / 2) / clk_hz;
  endfunction

  typedef enum logic {TONE_SPACE = 1'b0, TONE_MARK = 1'b1} tone_e;

endpackage

// File: rtl/fsk_step_sel.sv
module fsk_step_sel
  import fsk_pkg::*;
#(
  parameter longint CLK_HZ   = 3579545,
  parameter longint MARK_HZ  = 1300,
  parameter longint SPACE_HZ = 2100,
  parameter int     ACC_W    = 24
) (
  input  logic             tx_bit,
  output logic [ACC_W-1:0] step
);
  localparam logic [ACC_W-1:0] MARK_STEP  = ACC_W'(tone_step(MARK_HZ, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] SPACE_STEP = ACC_W'(tone_step(SPACE_HZ, CLK_HZ, ACC_W));

  tone_e tone;

  always_comb begin
    tone = tone_e'(tx_bit);
    unique case (tone)
      TONE_MARK:  step = MARK_STEP;
      TONE_SPACE: step = SPACE_STEP;
      default:    step = SPACE_STEP;
    endcase
  end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase,
  output logic             run_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      if (run) phase <= phase + step;
      else     phase <= '0;
    end
  end
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 8
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [SAMP_W-1:0] data
);
  localparam int     DEPTH = 1 << ADDR_W;
  localparam longint HALF  = longint'(DEPTH / 2);
  localparam longint AMP   = (longint'(1) << (SAMP_W - 1)) - 1;

  logic signed [SAMP_W-1:0] tbl [DEPTH];

  // Rational half-wave sine approximation, evaluated per entry at elaboration
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam longint P   = longint'(i) % HALF;
    localparam longint U   = P * (HALF - P);
    localparam longint DEN = 5 * HALF * HALF - 4 * U;
    localparam longint MAG = (16 * AMP * U + DEN / 2) / DEN;
    localparam longint VAL = (longint'(i) < HALF) ? MAG : -MAG;
    assign tbl[i] = SAMP_W'(VAL);
  end

  assign data = tbl[addr];
endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod #(
  parameter longint CLK_HZ   = 3579545,
  parameter longint MARK_HZ  = 1300,
  parameter longint SPACE_HZ = 2100,
  parameter int     ACC_W    = 24,
  parameter int     ADDR_W   = 8,
  parameter int     SAMP_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_en,
  input  logic                     tx_bit,
  output logic signed [SAMP_W-1:0] sample_o,
  output logic                     square_o
);
  logic [ACC_W-1:0]         step;
  logic [ACC_W-1:0]         phase_q;
  logic                     run_q;
  logic signed [SAMP_W-1:0] rom_data;

  fsk_step_sel #(
    .CLK_HZ(CLK_HZ), .MARK_HZ(MARK_HZ), .SPACE_HZ(SPACE_HZ), .ACC_W(ACC_W)
  ) u_step (
    .tx_bit(tx_bit),
    .step  (step)
  );

  fsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (tx_en),
    .step (step),
    .phase(phase_q),
    .run_q(run_q)
  );

  fsk_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .addr(phase_q[ACC_W-1 -: ADDR_W]),
    .data(rom_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o <= '0;
      square_o <= 1'b0;
    end else if (run_q) begin
      sample_o <= rom_data;
      square_o <= phase_q[ACC_W-1];
    end else begin
      sample_o <= '0;
      square_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fsk_tone_mod_chk.sv
module fsk_tone_mod_chk
  import fsk_pkg::*;
#(
  parameter longint CLK_HZ   = 3579545,
  parameter longint MARK_HZ  = 1300,
  parameter longint SPACE_HZ = 2100,
  parameter int     ACC_W    = 24,
  parameter int     SAMP_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tx_en,
  input logic                     tx_bit,
  input logic [ACC_W-1:0]         phase,
  input logic signed [SAMP_W-1:0] sample_o,
  input logic                     square_o
);
  localparam logic [ACC_W-1:0] M_INC = ACC_W'(tone_step(MARK_HZ, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] S_INC = ACC_W'(tone_step(SPACE_HZ, CLK_HZ, ACC_W));

  // R4 / R5: phase advances by the increment of the sampled bit, never reloads
  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> phase == ACC_W'($past(phase) + ($past(tx_bit) ? M_INC : S_INC)));

  // R6: disabled edge parks the phase
  assert_park_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> phase == '0);

  // R6: outputs silent from the second disabled edge
  assert_silent_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> ##1 (sample_o == '0 && !square_o));

  // R8: square high means non-positive half
  assert_square_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    square_o |-> sample_o <= 0);

  // R8: positive sample implies square low
  assert_pos_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o > 0 |-> !square_o);
endmodule

bind fsk_tone_mod fsk_tone_mod_chk #(
  .CLK_HZ(CLK_HZ), .MARK_HZ(MARK_HZ), .SPACE_HZ(SPACE_HZ),
  .ACC_W(ACC_W), .SAMP_W(SAMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit),
  .phase(phase_q), .sample_o(sample_o), .square_o(square_o)
);

// File: tb/fsk_tone_mod_bench.sv
`timescale 1ns/1ps
module fsk_tone_mod_bench;
  localparam real REF_HZ = 3579545.0;
  localparam int  NPER   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b1;
  logic signed [7:0] sample_o;
  logic square_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fsk_tone_mod u_fsk_tone_mod (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit),
    .sample_o(sample_o), .square_o(square_o)
  );

  task automatic check(input bit ok, input string req, input real act, input real exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles spanned by n square-wave periods, starting at a rising edge
  task automatic measure(input int n, output int cycles);
    logic prev;
    bit   r;
    int   rises;
    prev = square_o;
    do begin
      @(negedge clk);
      r = square_o && !prev;
      prev = square_o;
    end while (!r);
    cycles = 0;
    rises = 0;
    while (rises < n) begin
      @(negedge clk);
      cycles++;
      if (square_o && !prev) rises++;
      prev = square_o;
    end
  endtask

  task automatic t_reset_R1;
    tick(3);
    check(sample_o == 0 && square_o == 0, "R1 reset outputs", real'(sample_o), 0.0);
    rst_n = 1'b1;
    tick(5);
    check(sample_o == 0 && square_o == 0, "R1 idle before enable", real'(sample_o), 0.0);
  endtask

  task automatic t_tone(input bit b, input real f, input string rf);
    int  cyc_n;
    real expc, step, expx;
    tx_bit = b;
    tx_en = 1'b1;
    measure(NPER, cyc_n);
    expc = NPER * REF_HZ / f;
    check((cyc_n > expc * 0.999) && (cyc_n < expc * 1.001), rf, real'(cyc_n), expc);
    // R4: exact rounded increment
    step = $floor(f * 16777216.0 / REF_HZ + 0.5);
    expx = NPER * 16777216.0 / step;
    check((real'(cyc_n) > expx - 2.0) && (real'(cyc_n) < expx + 2.0),
          "R4 increment period", real'(cyc_n), expx);
  endtask

  task automatic t_disable_R6;
    tx_en = 1'b0;
    tick(2);
    check(sample_o == 0 && square_o == 0, "R6 silent after disable", real'(sample_o), 0.0);
    for (int i = 0; i < 40; i++) begin
      tx_bit = i[2];
      tick(1);
      if (sample_o != 0 || square_o) begin
        check(1'b0, "R6 bit ignored while disabled", real'(sample_o), 0.0);
        break;
      end
    end
    check(sample_o == 0, "R6 still zero", real'(sample_o), 0.0);
  endtask

  task automatic t_restart_R7;
    bit ok = 1'b1;
    bit rose = 1'b0;
    tx_bit = 1'b1;
    tx_en = 1'b1;
    tick(1);
    check(sample_o == 0, "R7 first sample zero", real'(sample_o), 0.0);
    for (int i = 0; i < 1300; i++) begin
      tick(1);
      if (sample_o < 0 || square_o) ok = 1'b0;
      if (sample_o > 0) rose = 1'b1;
    end
    check(ok && rose, "R7 starts at phase zero", real'(ok), 1.0);
  endtask

  task automatic t_shape_R9_R8(input bit b, input int span);
    int mx = -200;
    int mn = 200;
    bit sign_ok = 1'b1;
    tx_bit = b;
    for (int i = 0; i < span; i++) begin
      tick(1);
      if (int'(sample_o) > mx) mx = int'(sample_o);
      if (int'(sample_o) < mn) mn = int'(sample_o);
      if (square_o && sample_o > 0) sign_ok = 1'b0;
      if (!square_o && sample_o < 0) sign_ok = 1'b0;
    end
    check(mx == 127, "R9 peak positive", real'(mx), 127.0);
    check(mn == -127, "R9 peak negative", real'(mn), -127.0);
    check(sign_ok, "R8 square tracks sign", real'(sign_ok), 1.0);
  endtask

  task automatic t_switch_R5;
    int prev, d, worst;
    worst = 0;
    tick(1);
    prev = int'(sample_o);
    for (int i = 0; i < 6000; i++) begin
      if (i % 517 == 0) tx_bit = ~tx_bit;
      tick(1);
      d = int'(sample_o) - prev;
      if (d < 0) d = -d;
      if (d > worst) worst = d;
      prev = int'(sample_o);
    end
    check(worst <= 4, "R5 continuous across switches", real'(worst), 4.0);
  endtask

  initial begin
    t_reset_R1();
    t_restart_R7();
    t_tone(1'b1, 1300.0, "R2 mark 1300 Hz");
    t_tone(1'b0, 2100.0, "R3 space 2100 Hz");
    t_shape_R9_R8(1'b1, 2800);
    t_shape_R9_R8(1'b0, 1800);
    t_switch_R5();
    t_disable_R6();
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule